// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block collects single-cycle event pulses from the transmit and receive halves of an Ethernet DMA engine and holds each one in a sticky status bit. Software reads the status word, and clears bits by writing 1 to them. An enable register decides which status bits count towards two summaries. The abnormal summary covers error and stall conditions. The normal summary covers completion events. The interrupt output is raised when either summary is set.

A fatal bus error also drives a bus-disable output. The DMA engine uses that output to stop all bus traffic until software acknowledges the error. The early-receive bit is dropped by hardware in the cycle the receive-complete bit is first set, so software never sees both at once.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, every status bit and every enable bit is 0, and both the interrupt output and the bus-disable output are low.
- R2: A pulse on event input bit n sets status bit n one clock later. The sticky positions are 0–10, 13 and 14. A set bit stays set while no write-1 arrives for it, and a write of 0 to a status bit leaves it unchanged.
- R3: A write to address 0 clears every status bit whose data bit is 1. If an event pulse and a write-1 hit the same bit in the same cycle, the bit ends up set.
- R4: Status read bit 15 is the abnormal summary: the OR over bits 1, 3, 4, 5, 7, 8, 9, 10 and 13 of (status AND enable). It is computed from the current contents and cannot be written.
- R5: A status bit whose enable bit is 0 has no effect on either summary or on the interrupt output.
- R6: The normal summary is the OR over bits 0, 2, 6 and 14 of (status AND enable). The interrupt output is the OR of the normal and abnormal summaries.
- R7: When status bit 6 goes from 0 to 1, bit 14 is 0 in the following cycle, even if a bit 14 event arrives in that same cycle.
- R8: The bus-disable output is high exactly while status bit 13 is set.
- R9: Positions 11 and 12 read as 0 in both registers and ignore writes and events. Enable bit 15 also reads as 0.
- R10: Read and write address 0 selects status, and address 1 selects the enable register. Enable bit n gates status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 16 | One-cycle event pulses, one per status position |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 status (write-1 clear), 1 enable |
| wrData | input | 16 | Write data |
| rdAddr | input | 1 | Read select: 0 status, 1 enable |
| rdData | output | 16 | Combinational read data |
| irqOut | output | 1 | Interrupt request |
| busDisable | output | 1 | Bus access stop request |

## Verification
The hardest situations to reach are collisions inside one cycle. One is a bit 6 rising edge that meets a bit 14 event. Another is a write-1 clear that lands on a bit receiving a new pulse. Sparse random pulses rarely line these up. Directed sequences therefore force each collision, and a long random run follows. In that run, enable writes, clears and events are drawn with weights, so the summaries keep flipping while a bench model tracks every bit.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W   = 16;
  localparam int ERI_BIT = 14;
  localparam int RI_BIT  = 6;
  localparam int FBE_BIT = 13;
  localparam logic [REG_W-1:0] ABN_SRC = 16'h27BA;  // 1,3,4,5,7,8,9,10,13
  localparam logic [REG_W-1:0] NRM_SRC = 16'h4045;  // 0,2,6,14
  localparam logic [REG_W-1:0] STICKY  = ABN_SRC | NRM_SRC;

  typedef struct packed {
    logic [REG_W-1:0] statClr;
    logic             maskWr;
    logic [REG_W-1:0] maskData;
  } regStrb_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REG_W-1:0] wrData,
  output regStrb_t         strb
);
  always_comb begin
    strb.statClr  = (wrEn && !wrAddr) ? wrData : '0;
    strb.maskWr   = wrEn && wrAddr;
    strb.maskData = wrData;
  end
endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] evtIn,
  input  regStrb_t         strb,
  input  logic             rdAddr,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut,
  output logic             busDisable
);
  logic [REG_W-1:0] statQ, nextStat, maskQ;
  logic riRise, abnSum, nrmSum;

  assign riRise = evtIn[RI_BIT] && !statQ[RI_BIT];

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b == ERI_BIT) begin : g_eri
      assign nextStat[b] = !riRise && (evtIn[b] || (statQ[b] && !strb.statClr[b]));
    end else begin : g_std
      assign nextStat[b] = evtIn[b] || (statQ[b] && !strb.statClr[b]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= nextStat & STICKY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWr) maskQ <= strb.maskData & STICKY;
  end

  assign abnSum     = |(statQ & maskQ & ABN_SRC);
  assign nrmSum     = |(statQ & maskQ & NRM_SRC);
  assign irqOut     = abnSum || nrmSum;
  assign busDisable = statQ[FBE_BIT];
  assign rdData     = rdAddr ? maskQ : {abnSum, statQ[REG_W-2:0]};

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & $past(statQ & ~strb.statClr & STICKY & ~(16'h1 << ERI_BIT)))
              == $past(statQ & ~strb.statClr & STICKY & ~(16'h1 << ERI_BIT)))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & $past(evtIn & STICKY & ~(16'h1 << ERI_BIT)))
              == $past(evtIn & STICKY & ~(16'h1 << ERI_BIT)))); // R3
  AST_ERI_AUTOCLR: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn[RI_BIT] && !statQ[RI_BIT]) |=> !statQ[ERI_BIT]); // R7
  AST_BUSDIS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDisable) |-> $past(evtIn[FBE_BIT])); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[12:11] == 2'b00) && (maskQ[12:11] == 2'b00)); // R9
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] evtIn,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut,
  output logic             busDisable
);
  regStrb_t strb;

  dma_irq_ctrl ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  dma_irq_datapath dp_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb), .rdAddr(rdAddr),
    .rdData(rdData), .irqOut(irqOut), .busDisable(busDisable)
  );
endmodule

// File: tb/dma_irq_status_tb.sv
`timescale 1ns/1ps
module dma_irq_status_tb_top;
  localparam logic [15:0] ABN = 16'h27BA;
  localparam logic [15:0] NRM = 16'h4045;
  localparam logic [15:0] STK = 16'h67FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] evtIn = '0;
  logic wrEn = 1'b0, wrAddr = 1'b0, rdAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic irqOut, busDisable;

  int nChecks = 0, nFails = 0;
  logic [15:0] mStat = '0, mMask = '0;

  always #10 clk = ~clk;

  dma_irq_status dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut),
    .busDisable(busDisable)
  );

  function automatic logic [15:0] expRead(logic a, logic [15:0] s, logic [15:0] m);
    logic abn = |(s & m & ABN);
    return a ? m : {abn, s[14:0]};
  endfunction

  function automatic logic expIrq(logic [15:0] s, logic [15:0] m);
    return |(s & m & (ABN | NRM));
  endfunction

  function automatic logic [15:0] nextStat(logic [15:0] s, logic [15:0] e,
                                            logic [15:0] clr);
    logic [15:0] n = ((s & ~clr) | e) & STK;
    if (e[6] && !s[6]) n[14] = 1'b0;
    return n;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    rdAddr = 1'b0; #1;
    check({tag, " status"}, rdData, expRead(1'b0, mStat, mMask));
    rdAddr = 1'b1; #1;
    check({tag, " enable"}, rdData, expRead(1'b1, mStat, mMask));
    check({tag, " irq"}, {15'd0, irqOut}, {15'd0, expIrq(mStat, mMask)});
    check({tag, " busdis"}, {15'd0, busDisable}, {15'd0, mStat[13]});
  endtask

  task automatic step(logic we, logic wa, logic [15:0] wd, logic [15:0] ev);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; evtIn = ev;
    @(posedge clk); #1;
    if (we && wa) mMask = wd & STK;
    mStat = nextStat(mStat, ev, (we && !wa) ? wd : 16'h0);
    @(negedge clk);
    wrEn = 1'b0; evtIn = '0;
  endtask

  initial begin
    #3_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    // R2: set by pulse, write 0 no effect; R5 masked -> irq low
    step(1'b0, 1'b0, 16'h0, 16'h0002);
    checkAll("R2 set");
    check("R5 masked irq", {15'd0, irqOut}, 16'h0);
    step(1'b1, 1'b0, 16'h0000, 16'h0);
    checkAll("R2 write0");
    // R10/R4: enable bit 1 -> summary bit 15
    step(1'b1, 1'b1, 16'hFFFF, 16'h0);
    checkAll("R10 enable map");
    check("R9 enable rsvd", rdData & 16'h9800, 16'h0);
    rdAddr = 1'b0; #1;
    check("R4 summary", {15'd0, rdData[15]}, 16'h1);
    // R4: writing bit 15 to status does nothing to the summary
    step(1'b1, 1'b0, 16'h8000, 16'h0);
    checkAll("R4 unwritable");
    // R3: clear and set-wins
    step(1'b1, 1'b0, 16'h0002, 16'h0002);
    checkAll("R3 set wins");
    step(1'b1, 1'b0, 16'h0002, 16'h0);
    checkAll("R3 clear");
    // R9: reserved ignore events and writes
    step(1'b0, 1'b0, 16'h0, 16'h1800);
    checkAll("R9 rsvd evt");
    check("R9 rsvd zero", rdData & 16'h1800, 16'h0);
    // R6: normal summary via bit 0 only
    step(1'b1, 1'b1, 16'h0001, 16'h0001);
    checkAll("R6 normal");
    rdAddr = 1'b0; #1;
    check("R6 abn stays low", {15'd0, rdData[15]}, 16'h0);
    step(1'b1, 1'b0, 16'h0001, 16'h0);
    // R7: early receive then receive complete
    step(1'b0, 1'b0, 16'h0, 16'h4000);
    checkAll("R7 eri set");
    step(1'b0, 1'b0, 16'h0, 16'h4040);
    checkAll("R7 eri autoclr");
    rdAddr = 1'b0; #1;
    check("R7 bit14", {15'd0, rdData[14]}, 16'h0);
    // R8: bus disable
    step(1'b0, 1'b0, 16'h0, 16'h2000);
    check("R8 busdis high", {15'd0, busDisable}, 16'h1);
    step(1'b1, 1'b0, 16'h2000, 16'h0);
    check("R8 busdis low", {15'd0, busDisable}, 16'h0);
    checkAll("R8 after clr");

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ev = 16'h0;
      logic we = ($urandom % 4) == 0;
      logic wa = $urandom % 3 == 0;
      logic [15:0] wd = $urandom;
      if ($urandom % 2) ev[$urandom % 16] = 1'b1;
      if ($urandom % 8 == 0) ev = ev | 16'h4040;
      step(we, wa, wd, ev);
      checkAll("R2 R3 R4 R6 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule